// File: doc/BRIEF.md
# Relative Branch Next-PC Unit

This unit works out the next program counter for jump-class instructions in a small processor. In that processor a byte is 7 bits wide and a word holds four of these bytes, so a word is 28 bits. On each request the unit receives the address of the current instruction, the length of that instruction in bytes, the current condition flags, a branch kind and two candidate offsets. One candidate offset comes from a register and the other comes from an immediate word. A select input chooses between them.

When the branch is taken, the unit adds the signed offset to the address just past the current instruction. When it is not taken, or when the kind is plain sequential, the result is the address just past the current instruction. All address arithmetic wraps modulo 2^28.

The result is registered. It appears one clock after the request, together with a valid strobe and a taken indication. The adder works one 7-bit byte lane at a time and passes a ripple carry between lanes, which matches the machine's byte layout.

Top module: `brc_next_pc`

## Requirements
- R1: While reset is asserted, and until the first accepted request afterwards, `res_valid` and `res_taken` are 0 and `res_pc` is 0.
- R2: `res_valid` is 1 exactly in the cycle after a cycle in which `req_valid` was 1 and the unit was out of reset.
- R3: With `br_kind` = 2'b01 (unconditional), the branch is always taken and `res_pc` = `cur_pc` + `ins_len` + offset.
- R4: With `br_kind` = 2'b10 (branch if equal), the branch is taken exactly when `flg_zero` is 1.
- R5: With `br_kind` = 2'b11 (signed less), the branch is taken exactly when `flg_sign` differs from `flg_ovf`.
- R6: With `br_kind` = 2'b00 (sequential), the branch is never taken, whatever the flags are.
- R7: When a branch is not taken, `res_pc` = `cur_pc` + `ins_len`, and the offset inputs have no effect.
- R8: `off_imm_sel` = 0 selects `off_reg` as the offset and `off_imm_sel` = 1 selects `off_imm`. The input that is not selected has no effect.
- R9: All sums wrap modulo 2^28, and the offset is treated as 28-bit two's complement, so negative offsets branch backwards.
- R10: `res_taken` is never 1 while `res_valid` is 0. In a cycle that follows no request, `res_pc` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the unit |
| req_valid | input | 1 | Request strobe |
| br_kind | input | 2 | 00 sequential, 01 unconditional, 10 if equal, 11 signed less |
| cur_pc | input | 28 | Address of the current instruction |
| ins_len | input | 4 | Instruction length in 7-bit bytes |
| off_reg | input | 28 | Offset value taken from a register |
| off_imm | input | 28 | Offset value taken from an immediate word |
| off_imm_sel | input | 1 | Offset source select: 1 = immediate, 0 = register |
| flg_zero | input | 1 | Zero flag |
| flg_sign | input | 1 | Sign flag |
| flg_ovf | input | 1 | Overflow flag |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_taken | output | 1 | The branch was taken |
| res_pc | output | 28 | Next program counter |

## Verification
Every request produces a result one cycle later, and nothing is carried over from one request to the next except the held `res_pc`. A wrong condition decode therefore shows up on `res_taken` in the very next cycle for the flag pattern that triggers it. A broken carry between byte lanes, or a wrong offset source, shows up at once as a wrong `res_pc` for any operand whose low lanes overflow. The bench sweeps every kind against all eight flag combinations and both offset sources, using operands that cross lane boundaries and the top of the address space. This means a fault of this kind is seen within a few requests.

// File: rtl/brc_pkg.sv
package brc_pkg;
  parameter int BYTE_W  = 7;
  parameter int NBYTES  = 4;
  parameter int ADDR_W  = BYTE_W * NBYTES;
  parameter int LEN_W   = 4;

  typedef enum logic [1:0] {
    BK_SEQ = 2'b00,
    BK_JMP = 2'b01,
    BK_JEQ = 2'b10,
    BK_JLT = 2'b11
  } brc_kind_e;
endpackage

// File: rtl/brc_lane_adder.sv
// Byte-lane ripple adder: sums two words lane by lane, wrapping at the top.
module brc_lane_adder #(
  parameter int BYTE_W = 7,
  parameter int NBYTES = 4,
  localparam int W = BYTE_W * NBYTES
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [NBYTES-1:0] lane_c;
  assign lane_c[0] = cin;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [BYTE_W-1:0] la, lb;
    assign la = a[i*BYTE_W +: BYTE_W];
    assign lb = b[i*BYTE_W +: BYTE_W];
    if (i < NBYTES - 1) begin : g_mid
      logic [BYTE_W:0] wide;
      assign wide = {1'b0, la} + {1'b0, lb} + {{BYTE_W{1'b0}}, lane_c[i]};
      assign sum[i*BYTE_W +: BYTE_W] = wide[BYTE_W-1:0];
      assign lane_c[i+1] = wide[BYTE_W];
    end else begin : g_top
      assign sum[i*BYTE_W +: BYTE_W] = la + lb + {{(BYTE_W-1){1'b0}}, lane_c[i]};
    end
  end
endmodule

// File: rtl/brc_cond_eval.sv
// Decides whether the branch of the given kind is taken under the given flags.
module brc_cond_eval
  import brc_pkg::*;
(
  input  brc_kind_e kind,
  input  logic      zf,
  input  logic      sf,
  input  logic      of,
  output logic      taken
);
  always_comb begin
    unique case (kind)
      BK_SEQ:  taken = 1'b0;
      BK_JMP:  taken = 1'b1;
      BK_JEQ:  taken = zf;
      BK_JLT:  taken = sf ^ of;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/brc_off_sel.sv
// Picks the branch offset; a not-taken branch contributes zero.
module brc_off_sel #(
  parameter int W = 28
) (
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] imm_val,
  input  logic         use_imm,
  input  logic         taken,
  output logic [W-1:0] off
);
  always_comb begin
    if (!taken)       off = '0;
    else if (use_imm) off = imm_val;
    else              off = reg_val;
  end
endmodule

// File: rtl/brc_next_pc.sv
module brc_next_pc
  import brc_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NB = NBYTES,
  parameter int LW = LEN_W,
  localparam int AW = BW * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    br_kind,
  input  logic [AW-1:0] cur_pc,
  input  logic [LW-1:0] ins_len,
  input  logic [AW-1:0] off_reg,
  input  logic [AW-1:0] off_imm,
  input  logic          off_imm_sel,
  input  logic          flg_zero,
  input  logic          flg_sign,
  input  logic          flg_ovf,
  output logic          res_valid,
  output logic          res_taken,
  output logic [AW-1:0] res_pc
);
  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  brc_kind_e kind;
  assign kind = brc_kind_e'(br_kind);

  logic          take;
  logic [AW-1:0] off_eff, fall_pc, new_pc, len_ext;

  brc_cond_eval u_cond (
    .kind (kind), .zf (flg_zero), .sf (flg_sign), .of (flg_ovf), .taken (take)
  );

  brc_off_sel #(.W(AW)) u_off (
    .reg_val (off_reg), .imm_val (off_imm), .use_imm (off_imm_sel),
    .taken (take), .off (off_eff)
  );

  assign len_ext = {{(AW-LW){1'b0}}, ins_len};

  brc_lane_adder #(.BYTE_W(BW), .NBYTES(NB)) u_fall (
    .a (cur_pc), .b (len_ext), .cin (1'b0), .sum (fall_pc)
  );

  brc_lane_adder #(.BYTE_W(BW), .NBYTES(NB)) u_tgt (
    .a (fall_pc), .b (off_eff), .cin (1'b0), .sum (new_pc)
  );

  // next-state
  logic          valid_d, taken_d, pc_en;
  logic [AW-1:0] pc_d;
  always_comb begin
    valid_d = req_valid;
    taken_d = req_valid & take;
    pc_en   = req_valid;
    pc_d    = new_pc;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      res_valid <= 1'b0;
      res_taken <= 1'b0;
    end else begin
      res_valid <= valid_d;
      res_taken <= taken_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     res_pc <= '0;
    else if (pc_en) res_pc <= pc_d;
  end
endmodule

// File: rtl/brc_next_pc_chk.sv
module brc_next_pc_chk #(
  parameter int AW = 28,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_q,
  input logic          req_valid,
  input logic [1:0]    br_kind,
  input logic [AW-1:0] cur_pc,
  input logic [LW-1:0] ins_len,
  input logic          flg_zero,
  input logic          flg_sign,
  input logic          flg_ovf,
  input logic          res_valid,
  input logic          res_taken,
  input logic [AW-1:0] res_pc
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> res_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> !res_valid);
  p_jmp_taken_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && br_kind == 2'b01) |=> res_taken);
  p_jeq_flag_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && br_kind == 2'b10) |=> (res_taken == $past(flg_zero)));
  p_jlt_flag_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && br_kind == 2'b11) |=> (res_taken == ($past(flg_sign) != $past(flg_ovf))));
  p_seq_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && br_kind == 2'b00) |=> !res_taken);
  p_seq_fall_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && br_kind == 2'b00) |=>
      (res_pc == $past(cur_pc) + {{(AW-LW){1'b0}}, $past(ins_len)}));
  p_taken_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_q)
    res_taken |-> res_valid);
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> $stable(res_pc));
endmodule

bind brc_next_pc brc_next_pc_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk (clk), .rst_q (rst_q), .req_valid (req_valid), .br_kind (br_kind),
  .cur_pc (cur_pc), .ins_len (ins_len), .flg_zero (flg_zero),
  .flg_sign (flg_sign), .flg_ovf (flg_ovf), .res_valid (res_valid),
  .res_taken (res_taken), .res_pc (res_pc)
);

// File: tb/brc_next_pc_test.sv
`timescale 1ns/1ps
module brc_next_pc_test;
  localparam int AW = 28;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    br_kind;
  logic [AW-1:0] cur_pc, off_reg, off_imm;
  logic [LW-1:0] ins_len;
  logic          off_imm_sel, flg_zero, flg_sign, flg_ovf;
  logic          res_valid, res_taken;
  logic [AW-1:0] res_pc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  brc_next_pc uut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .br_kind (br_kind),
    .cur_pc (cur_pc), .ins_len (ins_len), .off_reg (off_reg), .off_imm (off_imm),
    .off_imm_sel (off_imm_sel), .flg_zero (flg_zero), .flg_sign (flg_sign),
    .flg_ovf (flg_ovf), .res_valid (res_valid), .res_taken (res_taken),
    .res_pc (res_pc)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%07h expected=0x%07h", req, act, exp);
    end
  endtask

  function automatic string kind_tag(input logic [1:0] k);
    case (k)
      2'b00:   return "R6";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [AW-1:0] pc_pat(input int v);
    case (v)
      0:       return 28'h0000000;
      1:       return 28'h000007E;   // low lane near its top
      2:       return 28'hFFFFFFD;   // near the top of the address space
      default: return 28'h5A5A5A5;
    endcase
  endfunction

  function automatic logic [AW-1:0] roff_pat(input int v);
    case (v)
      0:       return 28'h0000010;
      1:       return 28'hFFFFFF6;   // -10
      2:       return 28'h0000005;
      default: return 28'h0123456;
    endcase
  endfunction

  function automatic logic [AW-1:0] ioff_pat(input int v);
    case (v)
      0:       return 28'hFFFFF00;
      1:       return 28'h0000081;
      2:       return 28'h8000000;
      default: return 28'hFFFFFFF;   // -1
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] hold_pc;
    rst_n = 1'b0; req_valid = 1'b0; br_kind = 2'b00; cur_pc = '0; ins_len = '0;
    off_reg = '0; off_imm = '0; off_imm_sel = 1'b0;
    flg_zero = 1'b0; flg_sign = 1'b0; flg_ovf = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", {27'd0, res_valid}, '0);
    chk("R1 taken", {27'd0, res_taken}, '0);
    chk("R1 pc", res_pc, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after release", {27'd0, res_valid}, '0);
    chk("R1 pc after release", res_pc, '0);

    // sweep: kinds x flags x offset source x operand patterns
    for (int k = 0; k < 4; k++) begin
      for (int f = 0; f < 8; f++) begin
        for (int s = 0; s < 2; s++) begin
          for (int v = 0; v < 4; v++) begin
            logic          t;
            logic [AW-1:0] off, exp_pc;
            br_kind = 2'(k);
            flg_zero = f[0]; flg_sign = f[1]; flg_ovf = f[2];
            off_imm_sel = s[0];
            cur_pc = pc_pat(v);
            ins_len = LW'(1 + ((v + f) % 6));
            off_reg = roff_pat(v);
            off_imm = ioff_pat(v);
            req_valid = 1'b1;
            case (k)
              0:       t = 1'b0;
              1:       t = 1'b1;
              2:       t = f[0];
              default: t = f[1] ^ f[2];
            endcase
            off = s[0] ? ioff_pat(v) : roff_pat(v);  // R8 source select
            exp_pc = t ? cur_pc + AW'(ins_len) + off   // R9 wraps at 28 bits
                       : cur_pc + AW'(ins_len);        // R7 fall-through
            @(negedge clk);
            chk("R2 valid", {27'd0, res_valid}, 28'd1);
            chk(kind_tag(2'(k)), {27'd0, res_taken}, {27'd0, t});
            chk(t ? (s[0] ? "R8 R9 imm target" : "R8 R9 reg target") : "R7 fall",
                res_pc, exp_pc);
          end
        end
      end
    end

    // R9: explicit wrap and backward branch
    req_valid = 1'b1; br_kind = 2'b01; off_imm_sel = 1'b0;
    cur_pc = 28'hFFFFFFE; ins_len = 4'd5; off_reg = 28'd0;
    @(negedge clk);
    chk("R9 wrap", res_pc, 28'h0000003);
    cur_pc = 28'h0000100; ins_len = 4'd3; off_reg = 28'hFFFFFF0;
    @(negedge clk);
    chk("R9 backward", res_pc, 28'h00000F3);

    // R10 / R2: idle cycles hold pc, clear strobes; changed inputs ignored
    hold_pc = 28'h00000F3;
    req_valid = 1'b0; br_kind = 2'b01; cur_pc = 28'h1234567; off_reg = 28'h7654321;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 idle valid", {27'd0, res_valid}, '0);
      chk("R10 idle taken", {27'd0, res_taken}, '0);
      chk("R10 hold pc", res_pc, hold_pc);
    end

    // R8: unselected source ignored
    req_valid = 1'b1; br_kind = 2'b01; off_imm_sel = 1'b1;
    cur_pc = 28'd0; ins_len = 4'd2; off_imm = 28'd10; off_reg = 28'hABCDEF0;
    @(negedge clk);
    chk("R8 reg ignored", res_pc, 28'd12);
    req_valid = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule